// File: doc/BRIEF.md
# Interrupt masking and vectoring unit

This block is the interrupt-entry stage of a small processor. It holds a 32-bit machine state word with enable, privilege, trace and vector-prefix bits. Each cycle it looks at the pending request lines for machine-check, critical, system-management, external and decrementer interrupts. It also looks at the retirement strobe, which can raise a trace event. The state bits mask the requests. The highest-priority request that survives is taken.

Taking an interrupt costs one clock. On that edge the block does four things: it registers the physical vector address, pulses a valid strobe, saves the current program counter and state word into a save pair, and rewrites the state word. The rewrite moves the processor to supervisor level, turns tracing off and closes the enables of the class taken and of every class below it. Critical interrupts use their own save pair. A normal return pulse restores the state word from the normal pair. A critical return pulse restores it from the critical pair.

Software loads the state word through a simple write port. The surrounding pipeline supplies the program counter to save.

Top module: `irq_entry_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the state word, all four save registers, the vector address and the valid strobe are all zero.
- R2: When state bit 16 is 0, the system-management, external and decrementer requests produce no vector and leave the state word unchanged. When bit 16 is 1, they may be taken.
- R3: When state bit 19 is 0, a machine-check request produces no vector.
- R4: When state bit 24 is 0, a critical request produces no vector.
- R5: When several enabled sources are active, the block takes them in this fixed order: machine check, critical, system management, external, decrementer, trace.
- R6: The vector offsets are 0x00200 (machine check), 0x00A00 (critical), 0x01400 (system management), 0x00500 (external), 0x00900 (decrementer) and 0x00D00 (trace). Vector bits 19:0 hold the offset. Vector bits 31:20 are 0xFFF when state bit 25 was 1 at acceptance, and 0x000 otherwise.
- R7: The vector and the valid strobe appear in the cycle after the request is sampled. The strobe lasts one cycle. A request that stays held after its enable has been cleared is not taken again.
- R8: On a critical entry, the critical pair receives the program counter (pair word 0) and the old state (pair word 1), and the normal pair is left unchanged. Every other entry writes the normal pair in the same way and leaves the critical pair unchanged.
- R9: On any entry, state bits 17 (user level), 21 (single-step) and 22 (branch trace) are cleared. A machine-check entry also clears bits 16, 19 and 24. A critical entry also clears bits 16 and 24. A system-management, external or decrementer entry also clears bit 16. A trace entry clears no enable bit.
- R10: A retirement with state bit 21 set raises a trace entry. A retirement flagged as a branch with state bit 22 set also raises one. A non-branch retirement with only bit 22 set raises nothing.
- R11: A normal return pulse loads the state word from normal pair word 1 on the next edge.
- R12: A critical return pulse loads the state word from critical pair word 1 only if bit 24 of that saved word is 1. Otherwise the pulse is ignored.
- R13: Within one cycle, an interrupt entry takes precedence over a valid critical return. A valid critical return takes precedence over a normal return. A normal return takes precedence over a state write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_wr | input | 1 | Load the state word from state_wdata |
| state_wdata | input | 32 | New state word |
| pc_in | input | 32 | Program counter to save on entry |
| req_mchk | input | 1 | Machine-check request level |
| req_crit | input | 1 | Critical request level |
| req_smi | input | 1 | System-management request level |
| req_ext | input | 1 | External request level |
| req_dec | input | 1 | Decrementer request level |
| retire | input | 1 | An instruction completed successfully this cycle |
| retire_branch | input | 1 | The retiring instruction is a branch |
| ret_pulse | input | 1 | Normal return |
| cret_pulse | input | 1 | Critical return |
| state_q | output | 32 | Current state word |
| vec_valid | output | 1 | One-cycle strobe marking a new vector |
| vec_addr | output | 32 | Physical vector address of the last entry |
| save0 | output | 32 | Normal pair: saved program counter |
| save1 | output | 32 | Normal pair: saved state word |
| csave0 | output | 32 | Critical pair: saved program counter |
| csave1 | output | 32 | Critical pair: saved state word |

## Verification
The bench drives all request lines at once, in several enable settings. A priority chain that is out of order would vector to the wrong offset. A group mask wired to the wrong bit would either take a masked source or miss an enabled one. The bench holds a request across its own entry: a design that fails to clear the enable would strobe again. It takes a critical entry while a normal entry is still saved, so writing the wrong save pair would corrupt the other pair's contents. It also sends a critical return when the saved critical word has bit 24 at 0, fires return, write and request together, and retires branches and non-branches under each trace bit alone. A wrong precedence order or a trace condition that ignores the branch flag would each leave a different state word than the reference model.

// File: rtl/irq_entry_unit.sv
module irq_entry_unit #(
  parameter logic [19:0] OFS_MCHK = 20'h00200,
  parameter logic [19:0] OFS_CRIT = 20'h00A00,
  parameter logic [19:0] OFS_SMI  = 20'h01400,
  parameter logic [19:0] OFS_EXT  = 20'h00500,
  parameter logic [19:0] OFS_DEC  = 20'h00900,
  parameter logic [19:0] OFS_TRC  = 20'h00D00,
  parameter logic [11:0] HI_BASE  = 12'hFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        state_wr,
  input  logic [31:0] state_wdata,
  input  logic [31:0] pc_in,
  input  logic        req_mchk,
  input  logic        req_crit,
  input  logic        req_smi,
  input  logic        req_ext,
  input  logic        req_dec,
  input  logic        retire,
  input  logic        retire_branch,
  input  logic        ret_pulse,
  input  logic        cret_pulse,
  output logic [31:0] state_q,
  output logic        vec_valid,
  output logic [31:0] vec_addr,
  output logic [31:0] save0,
  output logic [31:0] save1,
  output logic [31:0] csave0,
  output logic [31:0] csave1
);
  localparam int B_EE = 16;
  localparam int B_PR = 17;
  localparam int B_ME = 19;
  localparam int B_SE = 21;
  localparam int B_BE = 22;
  localparam int B_CE = 24;
  localparam int B_IP = 25;
  localparam logic [31:0] M_EE = 32'h1 << B_EE;
  localparam logic [31:0] M_ME = 32'h1 << B_ME;
  localparam logic [31:0] M_CE = 32'h1 << B_CE;
  localparam logic [31:0] M_ENTRY = (32'h1 << B_PR) | (32'h1 << B_SE) | (32'h1 << B_BE);

  wire trace_ev = retire && (state_q[B_SE] || (state_q[B_BE] && retire_branch));
  wire take_mc  = req_mchk && state_q[B_ME];
  wire take_cr  = req_crit && state_q[B_CE];
  wire take_sm  = req_smi  && state_q[B_EE];
  wire take_ex  = req_ext  && state_q[B_EE];
  wire take_de  = req_dec  && state_q[B_EE];
  wire cret_ok  = cret_pulse && csave1[B_CE];

  logic        hit;
  logic        to_crit;
  logic [19:0] ofs;
  logic [31:0] clr;

  always_comb begin
    hit     = 1'b1;
    to_crit = 1'b0;
    ofs     = '0;
    clr     = M_ENTRY;
    if (take_mc) begin
      ofs = OFS_MCHK;
      clr = clr | M_EE | M_ME | M_CE;
    end else if (take_cr) begin
      ofs     = OFS_CRIT;
      to_crit = 1'b1;
      clr     = clr | M_EE | M_CE;
    end else if (take_sm) begin
      ofs = OFS_SMI;
      clr = clr | M_EE;
    end else if (take_ex) begin
      ofs = OFS_EXT;
      clr = clr | M_EE;
    end else if (take_de) begin
      ofs = OFS_DEC;
      clr = clr | M_EE;
    end else if (trace_ev) begin
      ofs = OFS_TRC;
    end else begin
      hit = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= '0;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      save0     <= '0;
      save1     <= '0;
      csave0    <= '0;
      csave1    <= '0;
    end else begin
      vec_valid <= hit;
      if (hit) begin
        vec_addr <= {state_q[B_IP] ? HI_BASE : 12'h000, ofs};
        if (to_crit) begin
          csave0 <= pc_in;
          csave1 <= state_q;
        end else begin
          save0 <= pc_in;
          save1 <= state_q;
        end
        state_q <= state_q & ~clr;
      end else if (cret_ok) begin
        state_q <= csave1;
      end else if (ret_pulse) begin
        state_q <= save1;
      end else if (state_wr) begin
        state_q <= state_wdata;
      end
    end
  end

  assert_group_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && (vec_addr[19:0] == OFS_EXT || vec_addr[19:0] == OFS_SMI || vec_addr[19:0] == OFS_DEC))
      |-> $past(state_q[B_EE]));

  assert_mchk_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_addr[19:0] == OFS_MCHK) |-> $past(state_q[B_ME]));

  assert_crit_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_addr[19:0] == OFS_CRIT) |-> $past(state_q[B_CE]));

  assert_prefix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr[31:20] == ($past(state_q[B_IP]) ? HI_BASE : 12'h000)));

  assert_entry_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (!state_q[B_PR] && !state_q[B_SE] && !state_q[B_BE]));

  assert_crit_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_addr[19:0] == OFS_CRIT) |-> $stable(save1));
endmodule

// File: tb/tb_irq_entry_unit.sv
module tb_irq_entry_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic state_wr = 0, req_mchk = 0, req_crit = 0, req_smi = 0, req_ext = 0, req_dec = 0;
  logic retire = 0, retire_branch = 0, ret_pulse = 0, cret_pulse = 0;
  logic [31:0] state_wdata = '0, pc_in = '0;
  logic [31:0] state_q, vec_addr, save0, save1, csave0, csave1;
  logic vec_valid;

  always #5 clk = ~clk;

  irq_entry_unit dut (
    .clk(clk), .rst_n(rst_n), .state_wr(state_wr), .state_wdata(state_wdata), .pc_in(pc_in),
    .req_mchk(req_mchk), .req_crit(req_crit), .req_smi(req_smi), .req_ext(req_ext),
    .req_dec(req_dec), .retire(retire), .retire_branch(retire_branch),
    .ret_pulse(ret_pulse), .cret_pulse(cret_pulse), .state_q(state_q),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .save0(save0), .save1(save1),
    .csave0(csave0), .csave1(csave1));

  int checks = 0;
  int fails = 0;

  // reference model
  logic [31:0] m_st, m_s0, m_s1, m_c0, m_c1, m_va;
  logic m_vv;
  logic [19:0] offs [6];
  logic [5:0] want;
  int win;
  initial begin
    offs[0] = 20'h00200; offs[1] = 20'h00A00; offs[2] = 20'h01400;
    offs[3] = 20'h00500; offs[4] = 20'h00900; offs[5] = 20'h00D00;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_s0 = 0; m_s1 = 0; m_c0 = 0; m_c1 = 0; m_va = 0; m_vv = 0;
    end else begin
      want = {retire && (m_st[21] || (m_st[22] && retire_branch)),
              req_dec && m_st[16], req_ext && m_st[16], req_smi && m_st[16],
              req_crit && m_st[24], req_mchk && m_st[19]};
      win = -1;
      for (int i = 5; i >= 0; i--) if (want[i]) win = i;
      m_vv = (win >= 0);
      if (win >= 0) begin
        m_va = {m_st[25] ? 12'hFFF : 12'h000, offs[win]};
        if (win == 1) begin m_c0 = pc_in; m_c1 = m_st; end
        else begin m_s0 = pc_in; m_s1 = m_st; end
        m_st[17] = 0; m_st[21] = 0; m_st[22] = 0;
        if (win <= 4) m_st[16] = 0;
        if (win <= 1) m_st[24] = 0;
        if (win == 0) m_st[19] = 0;
      end else if (cret_pulse && m_c1[24]) m_st = m_c1;
      else if (ret_pulse) m_st = m_s1;
      else if (state_wr) m_st = state_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " model state"}, state_q, m_st);
    chk({tag, " model valid"}, {31'b0, vec_valid}, {31'b0, m_vv});
    chk({tag, " model vector"}, vec_addr, m_va);
    chk({tag, " model save0"}, save0, m_s0);
    chk({tag, " model save1"}, save1, m_s1);
    chk({tag, " model csave0"}, csave0, m_c0);
    chk({tag, " model csave1"}, csave1, m_c1);
  endtask

  task automatic idle();
    state_wr = 0; req_mchk = 0; req_crit = 0; req_smi = 0; req_ext = 0; req_dec = 0;
    retire = 0; retire_branch = 0; ret_pulse = 0; cret_pulse = 0;
  endtask

  task automatic wr(input logic [31:0] v);
    idle(); state_wr = 1; state_wdata = v; step("R13 write"); idle();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 state in reset", state_q, 0);
    chk("R1 valid in reset", {31'b0, vec_valid}, 0);
    rst_n = 1;
    step("R1");
    chk("R1 save1", save1, 0);
    chk("R1 csave1", csave1, 0);

    // R12: stray critical return with empty critical pair is ignored
    wr(32'h0001_0000);
    cret_pulse = 1; step("R12 stray"); idle();
    chk("R12 stray cret ignored", state_q, 32'h0001_0000);

    // R2 R3 R4: everything masked
    wr(32'h0);
    req_mchk = 1; req_crit = 1; req_smi = 1; req_ext = 1; req_dec = 1;
    step("R2");
    chk("R2 R3 R4 no vector when masked", {31'b0, vec_valid}, 0);
    chk("R2 state unchanged", state_q, 0);
    idle();

    // external with user level set
    wr(32'h0003_0000);
    pc_in = 32'h0000_1000; req_ext = 1; step("R6");
    chk("R6 external vector", vec_addr, 32'h0000_0500);
    chk("R8 save0 pc", save0, 32'h0000_1000);
    chk("R8 save1 state", save1, 32'h0003_0000);
    chk("R9 entry state", state_q, 0);
    step("R7");
    chk("R7 held request not retaken", {31'b0, vec_valid}, 0);
    idle();
    ret_pulse = 1; step("R11"); idle();
    chk("R11 normal return", state_q, 32'h0003_0000);

    // R5 within external group
    req_smi = 1; req_ext = 1; req_dec = 1; step("R5");
    chk("R5 smi first", vec_addr, 32'h0000_1400);
    idle(); ret_pulse = 1; step("R11"); idle();
    req_ext = 1; req_dec = 1; step("R5");
    chk("R5 ext over dec", vec_addr, 32'h0000_0500);
    idle(); ret_pulse = 1; step("R11"); idle();
    req_dec = 1; step("R6");
    chk("R6 dec vector", vec_addr, 32'h0000_0900);
    idle();

    // machine check with high prefix, all requests
    wr(32'h0309_0000);
    pc_in = 32'h0000_2000;
    req_mchk = 1; req_crit = 1; req_smi = 1; req_ext = 1; req_dec = 1; step("R5");
    chk("R5 R6 mchk high vector", vec_addr, 32'hFFF0_0200);
    chk("R9 mchk clears enables", state_q, 32'h0200_0000);
    idle();

    // critical entry keeps normal pair
    wr(32'h0309_0000);
    pc_in = 32'h0000_3000; req_crit = 1; req_ext = 1; step("R5");
    chk("R6 crit vector", vec_addr, 32'hFFF0_0A00);
    chk("R8 csave0", csave0, 32'h0000_3000);
    chk("R8 csave1", csave1, 32'h0309_0000);
    chk("R8 normal pair kept", save0, 32'h0000_2000);
    chk("R9 crit entry state", state_q, 32'h0208_0000);
    idle();
    cret_pulse = 1; ret_pulse = 1; step("R13 cret over ret"); idle();
    chk("R12 R13 critical return", state_q, 32'h0309_0000);

    // trace
    wr(32'h0020_0000);
    retire = 1; step("R10"); idle();
    chk("R10 single-step trace", vec_addr, 32'h0000_0D00);
    chk("R9 trace clears se", state_q, 0);
    wr(32'h0040_0000);
    retire = 1; step("R10"); idle();
    chk("R10 non-branch ignored", {31'b0, vec_valid}, 0);
    chk("R10 state kept", state_q, 32'h0040_0000);
    retire = 1; retire_branch = 1; step("R10"); idle();
    chk("R10 branch trace", {31'b0, vec_valid}, 1);

    // precedence: entry over write and return
    wr(32'h0001_0000);
    req_ext = 1; state_wr = 1; state_wdata = 32'hFFFF_FFFF; ret_pulse = 1;
    step("R13"); idle();
    chk("R13 entry wins", state_q, 0);
    step("R13 idle");

    finish_run();
  end
endmodule